// File: doc/BRIEF.md
# Receiver Polling Mode Sequencer

This block duty-cycles a radio receiver. It keeps the receive chain powered down for a programmable sleep interval. It then starts the synthesizer loop and waits for it to lock, and after that starts the signal-processing path. Next it enables an external bit-check unit and waits for that unit's verdict. When the verdict is good, the sequencer enters a receiving state and routes the demodulated stream to its serial output. When the verdict is bad, it either goes back to sleep or keeps checking.

Every waiting period is measured in half-periods of a basic clock, so the lock interval of 798.5 basic periods is timed exactly. A prescaler inside the block derives the half-period tick from the system clock. The sleep length comes from a 5-bit field with an extension flag. The signal-processing start-up length comes from a 2-bit baud-range field.

A pass verdict sets three sticky control bits: supply enable, clock-on and operating-mode bit 0. Once operating-mode bit 0 is set, a failed check no longer sends the block to sleep. A separate request input can pull the receiver out of the receiving state into an idle hold. This covers the case where the demodulator has lost lock after the data stream was interrupted.

Top module: `rx_poll_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, the block enters the sleep state. All of `pllEn`, `sigEn`, `checkEn`, `rxActive`, `serialOut`, `supplyEn`, `clkOn` and `opMode0` are then 0.
- R2: In sleep, `pllEn`, `sigEn`, `checkEn` and `rxActive` are all 0. Sleep lasts `sleepField` x 1024 basic periods, multiplied by 8 when `sleepExt` is 1. One basic period is 2*HALF_DIV clock cycles. Both fields are sampled when sleep is entered, and later changes do not alter the running interval.
- R3: PLL start-up (`pllEn`=1, `sigEn`=0) lasts exactly 1597 half-periods, which is 3194 cycles at HALF_DIV=2. It then moves to signal-processing start-up.
- R4: Signal-processing start-up (`pllEn`=`sigEn`=1, `checkEn`=0) lasts 1764, 996, 612 or 420 half-periods for `baudRange` 0, 1, 2 or 3. The range is sampled on entry. The state then moves to bit-check.
- R5: In bit-check, `pllEn`, `sigEn` and `checkEn` are 1 and `rxActive` is 0. The state is held for as long as `bitCheckValid` stays low.
- R6: A bit-check strobe (`bitCheckValid`=1) with `bitCheckPass`=1 sets `supplyEn`, `clkOn` and `opMode0` to 1 at the next edge and enters receiving (`rxActive`=1, `checkEn`=0). These bits stay 1 until reset.
- R7: A strobe with `bitCheckPass`=0 sends the block to sleep only if `opMode0`=0 and `sleepField` is nonzero. Otherwise the block stays in bit-check.
- R8: In receiving, `serialOut` follows `rxDataIn` in the same cycle. In every other state `serialOut` is 0.
- R9: In receiving, a failing strobe (a bit error) is ignored, and `rxActive` stays 1.
- R10: `forceIdle`=1 in receiving moves the block to an idle hold at the next edge, with all enables and `rxActive` at 0 and the control bits kept. The first edge with `forceIdle`=0 starts a new PLL start-up.
- R11: A sleep length of zero, whether loaded at reset or on entry, lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sleepField | input | 5 | Sleep length in units of 1024 basic periods |
| sleepExt | input | 1 | Multiplies the sleep length by 8 |
| baudRange | input | 2 | Selects the signal-processing start-up length |
| bitCheckValid | input | 1 | One-cycle strobe carrying a bit-check verdict |
| bitCheckPass | input | 1 | Verdict: 1 pass, 0 fail |
| forceIdle | input | 1 | Request to leave receiving for the idle hold |
| rxDataIn | input | 1 | Demodulated data stream |
| pllEn | output | 1 | Synthesizer loop enable |
| sigEn | output | 1 | Signal-processing path enable |
| checkEn | output | 1 | Bit-check unit enable |
| rxActive | output | 1 | High only in receiving |
| supplyEn | output | 1 | Sticky output-supply enable bit |
| clkOn | output | 1 | Sticky clock-on bit |
| opMode0 | output | 1 | Sticky operating-mode bit 0 |
| serialOut | output | 1 | Gated data output |

## Verification
Each timed state ends exactly N*HALF_DIV cycles after the edge that entered it, where N is the number of half-periods loaded. The bench therefore samples at falling edges and counts the cycles from the first falling edge at which a state is visible to the first falling edge at which the next one is visible. That count must equal the interval exactly. Strobe and force responses are due one edge later, so they are read at the next falling edge. The serial pass-through is combinational and is read within the same cycle. Fields are changed right after a state is entered, to show that the running interval ignores them.

// File: rtl/rx_poll_pkg.sv
package rx_poll_pkg;

  typedef enum logic [2:0] {
    ST_SLEEP = 3'd0,
    ST_PLL   = 3'd1,
    ST_SIG   = 3'd2,
    ST_CHECK = 3'd3,
    ST_RECV  = 3'd4,
    ST_IDLE  = 3'd5
  } seqState_t;

  // Strobes from the control FSM to the timing datapath
  typedef struct packed {
    logic loadSleep;
    logic loadPll;
    logic loadSig;
    logic setCtl;
  } seqStrobe_t;

endpackage

// File: rtl/rx_poll_timer.sv
module rx_poll_timer
  import rx_poll_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int SLEEP_W    = 5,
  parameter int UNIT_SHIFT = 10,
  parameter int EXT_SHIFT  = 3,
  parameter int PLL_HALF   = 1597,
  parameter int SIG_HALF0  = 1764,
  parameter int SIG_HALF1  = 996,
  parameter int SIG_HALF2  = 612,
  parameter int SIG_HALF3  = 420
) (
  input  logic               clk,
  input  logic               rst,
  input  seqStrobe_t         strobe,
  input  logic [SLEEP_W-1:0] sleepField,
  input  logic               sleepExt,
  input  logic [1:0]         baudRange,
  output logic               expired,
  output logic               supplyEn,
  output logic               clkOn,
  output logic               opMode0
);

  localparam int SLEEP_BITS = SLEEP_W + UNIT_SHIFT + 1 + EXT_SHIFT;
  localparam int PLL_BITS   = $clog2(PLL_HALF + 1);
  localparam int TIMER_W    = (SLEEP_BITS > PLL_BITS) ? SLEEP_BITS : PLL_BITS;
  localparam int PRE_W      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [TIMER_W-1:0] timerQ;
  logic [TIMER_W-1:0] sleepBase;
  logic [TIMER_W-1:0] sleepHalf;
  logic [TIMER_W-1:0] sigHalf;
  logic               halfTick;

  // Sleep length in half-periods: field * 1024 * 2, optionally * 8
  always_comb begin
    sleepBase = TIMER_W'(sleepField) << (UNIT_SHIFT + 1);
    sleepHalf = sleepExt ? (sleepBase << EXT_SHIFT) : sleepBase;
  end

  always_comb begin
    case (baudRange)
      2'd0:    sigHalf = TIMER_W'(SIG_HALF0);
      2'd1:    sigHalf = TIMER_W'(SIG_HALF1);
      2'd2:    sigHalf = TIMER_W'(SIG_HALF2);
      default: sigHalf = TIMER_W'(SIG_HALF3);
    endcase
  end

  // Half-period tick; the prescaler restarts whenever a timed state is entered
  generate
    if (HALF_DIV == 1) begin : g_noDiv
      assign halfTick = 1'b1;
    end else begin : g_div
      logic [PRE_W-1:0] preCnt;
      logic             anyLoad;
      assign anyLoad  = strobe.loadSleep | strobe.loadPll | strobe.loadSig;
      assign halfTick = (preCnt == PRE_W'(HALF_DIV - 1));
      always_ff @(posedge clk) begin
        if (rst || anyLoad)  preCnt <= '0;
        else if (halfTick)   preCnt <= '0;
        else                 preCnt <= preCnt + 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                    timerQ <= sleepHalf;
    else if (strobe.loadSleep)  timerQ <= sleepHalf;
    else if (strobe.loadPll)    timerQ <= TIMER_W'(PLL_HALF);
    else if (strobe.loadSig)    timerQ <= sigHalf;
    else if (halfTick && (timerQ != '0)) timerQ <= timerQ - 1'b1;
  end

  // Interval ends on the tick that would take the count to zero
  assign expired = (timerQ == '0) | (halfTick & (timerQ == TIMER_W'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      supplyEn <= 1'b0;
      clkOn    <= 1'b0;
      opMode0  <= 1'b0;
    end else if (strobe.setCtl) begin
      supplyEn <= 1'b1;
      clkOn    <= 1'b1;
      opMode0  <= 1'b1;
    end
  end

endmodule

// File: rtl/rx_poll_fsm.sv
module rx_poll_fsm
  import rx_poll_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       expired,
  input  logic       bitCheckValid,
  input  logic       bitCheckPass,
  input  logic       forceIdle,
  input  logic       opMode0,
  input  logic       sleepNonZero,
  output seqStrobe_t strobe,
  output logic       pllEn,
  output logic       sigEn,
  output logic       checkEn,
  output logic       rxActive
);

  seqState_t stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    case (stateQ)
      ST_SLEEP: if (expired) begin
        stateD = ST_PLL;
        strobe.loadPll = 1'b1;
      end
      ST_PLL: if (expired) begin
        stateD = ST_SIG;
        strobe.loadSig = 1'b1;
      end
      ST_SIG: if (expired) stateD = ST_CHECK;
      ST_CHECK: if (bitCheckValid) begin
        if (bitCheckPass) begin
          stateD = ST_RECV;
          strobe.setCtl = 1'b1;
        end else if (!opMode0 && sleepNonZero) begin
          stateD = ST_SLEEP;
          strobe.loadSleep = 1'b1;
        end
      end
      // Bit errors are not routed here: only the idle request leaves receiving
      ST_RECV: if (forceIdle) stateD = ST_IDLE;
      ST_IDLE: if (!forceIdle) begin
        stateD = ST_PLL;
        strobe.loadPll = 1'b1;
      end
      default: stateD = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_SLEEP;
    else     stateQ <= stateD;
  end

  always_comb begin
    pllEn    = 1'b0;
    sigEn    = 1'b0;
    checkEn  = 1'b0;
    rxActive = 1'b0;
    case (stateQ)
      ST_PLL:   pllEn = 1'b1;
      ST_SIG:   begin pllEn = 1'b1; sigEn = 1'b1; end
      ST_CHECK: begin pllEn = 1'b1; sigEn = 1'b1; checkEn = 1'b1; end
      ST_RECV:  begin pllEn = 1'b1; sigEn = 1'b1; rxActive = 1'b1; end
      default:  ;
    endcase
  end

endmodule

// File: rtl/rx_poll_sequencer.sv
module rx_poll_sequencer
  import rx_poll_pkg::*;
#(
  parameter int HALF_DIV   = 2,
  parameter int SLEEP_W    = 5,
  parameter int UNIT_SHIFT = 10,
  parameter int EXT_SHIFT  = 3,
  parameter int PLL_HALF   = 1597,
  parameter int SIG_HALF0  = 1764,
  parameter int SIG_HALF1  = 996,
  parameter int SIG_HALF2  = 612,
  parameter int SIG_HALF3  = 420
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [SLEEP_W-1:0] sleepField,
  input  logic               sleepExt,
  input  logic [1:0]         baudRange,
  input  logic               bitCheckValid,
  input  logic               bitCheckPass,
  input  logic               forceIdle,
  input  logic               rxDataIn,
  output logic               pllEn,
  output logic               sigEn,
  output logic               checkEn,
  output logic               rxActive,
  output logic               supplyEn,
  output logic               clkOn,
  output logic               opMode0,
  output logic               serialOut
);

  seqStrobe_t strobe;
  logic       expired;

  rx_poll_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .expired      (expired),
    .bitCheckValid(bitCheckValid),
    .bitCheckPass (bitCheckPass),
    .forceIdle    (forceIdle),
    .opMode0      (opMode0),
    .sleepNonZero (|sleepField),
    .strobe       (strobe),
    .pllEn        (pllEn),
    .sigEn        (sigEn),
    .checkEn      (checkEn),
    .rxActive     (rxActive)
  );

  rx_poll_timer #(
    .HALF_DIV  (HALF_DIV),
    .SLEEP_W   (SLEEP_W),
    .UNIT_SHIFT(UNIT_SHIFT),
    .EXT_SHIFT (EXT_SHIFT),
    .PLL_HALF  (PLL_HALF),
    .SIG_HALF0 (SIG_HALF0),
    .SIG_HALF1 (SIG_HALF1),
    .SIG_HALF2 (SIG_HALF2),
    .SIG_HALF3 (SIG_HALF3)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .sleepField(sleepField),
    .sleepExt  (sleepExt),
    .baudRange (baudRange),
    .expired   (expired),
    .supplyEn  (supplyEn),
    .clkOn     (clkOn),
    .opMode0   (opMode0)
  );

  assign serialOut = rxActive & rxDataIn;

endmodule

// File: rtl/rx_poll_sequencer_chk.sv
module rx_poll_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic bitCheckValid,
  input logic bitCheckPass,
  input logic forceIdle,
  input logic pllEn,
  input logic sigEn,
  input logic checkEn,
  input logic rxActive,
  input logic supplyEn,
  input logic clkOn,
  input logic opMode0,
  input logic serialOut
);

  assert_quiet_when_off_R2: assert property (@(posedge clk) disable iff (rst)
    !pllEn |-> (!sigEn && !checkEn && !rxActive));

  assert_check_after_sig_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(checkEn) |-> $past(sigEn && !checkEn));

  assert_ctl_sticky_R6: assert property (@(posedge clk) disable iff (rst)
    opMode0 |=> opMode0);

  assert_ctl_together_R6: assert property (@(posedge clk) disable iff (rst)
    (supplyEn == opMode0) && (clkOn == opMode0));

  assert_rx_entry_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rxActive) |-> ($past(checkEn && bitCheckValid && bitCheckPass) && opMode0));

  assert_fail_stays_R7: assert property (@(posedge clk) disable iff (rst)
    (checkEn && bitCheckValid && !bitCheckPass && opMode0) |=> checkEn);

  assert_serial_gated_R8: assert property (@(posedge clk) disable iff (rst)
    !rxActive |-> !serialOut);

  assert_biterr_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (rxActive && !forceIdle) |=> rxActive);

  assert_force_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (rxActive && forceIdle) |=> (!pllEn && !rxActive));

endmodule

bind rx_poll_sequencer rx_poll_sequencer_chk u_chk (.*);

// File: tb/tb_rx_poll_sequencer.sv
module tb_rx_poll_sequencer;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] sleepField = '0;
  logic sleepExt = 1'b0;
  logic [1:0] baudRange = '0;
  logic bitCheckValid = 1'b0;
  logic bitCheckPass = 1'b0;
  logic forceIdle = 1'b0;
  logic rxDataIn = 1'b0;
  logic pllEn, sigEn, checkEn, rxActive, supplyEn, clkOn, opMode0, serialOut;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_poll_sequencer #(.HALF_DIV(2)) dut (
    .clk(clk), .rst(rst), .sleepField(sleepField), .sleepExt(sleepExt),
    .baudRange(baudRange), .bitCheckValid(bitCheckValid),
    .bitCheckPass(bitCheckPass), .forceIdle(forceIdle), .rxDataIn(rxDataIn),
    .pllEn(pllEn), .sigEn(sigEn), .checkEn(checkEn), .rxActive(rxActive),
    .supplyEn(supplyEn), .clkOn(clkOn), .opMode0(opMode0), .serialOut(serialOut)
  );

  localparam int PLL_CYC = 3194;
  localparam int NV = 4;
  // field, ext, baud, expected sleep cycles, expected sig start-up cycles
  localparam int VEC [NV][5] = '{
    '{1, 0, 0, 4096,  3528},
    '{2, 0, 1, 8192,  1992},
    '{1, 1, 2, 32768, 1224},
    '{3, 0, 3, 12288, 840}
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // 0: pllEn, 1: sigEn, 2: checkEn
  function automatic bit sel(input int w);
    case (w)
      0: return pllEn;
      1: return sigEn;
      default: return checkEn;
    endcase
  endfunction

  task automatic countUntil(input int w, output int n);
    n = 0;
    while (!sel(w)) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic doReset(input logic [1:0] br);
    rst = 1'b1;
    sleepField = '0;
    sleepExt = 1'b0;
    baudRange = br;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic strobe(input logic pass);
    bitCheckValid = 1'b1;
    bitCheckPass = pass;
    @(negedge clk);
    bitCheckValid = 1'b0;
    bitCheckPass = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    rxDataIn = 1'b1;
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1 outputs in reset",
          int'({pllEn, sigEn, checkEn, rxActive, supplyEn, clkOn, opMode0, serialOut}), 0);

    for (int v = 0; v < NV; v++) begin
      doReset(VEC[v][2][1:0]);
      countUntil(0, n);
      check("R11 zero sleep after reset", n, 1);
      countUntil(1, n);
      check("R3 pll start-up", n, PLL_CYC);
      countUntil(2, n);
      check("R4 sig start-up", n, VEC[v][4]);
      // failing verdict with opMode0 = 0 and nonzero field -> sleep
      sleepField = VEC[v][0][4:0];
      sleepExt = VEC[v][1][0];
      strobe(1'b0);
      sleepField = '0;
      sleepExt = 1'b0;
      check("R7 fail goes to sleep", int'({pllEn, checkEn}), 0);
      countUntil(0, n);
      check("R2 sleep length sampled on entry", n, VEC[v][3]);
      countUntil(1, n);
      check("R3 pll start-up again", n, PLL_CYC);
      countUntil(2, n);
      check("R4 sig start-up again", n, VEC[v][4]);
      strobe(1'b1);
      check("R6 pass enters receiving",
            int'({rxActive, checkEn, supplyEn, clkOn, opMode0}), 5'b10111);
    end

    // R8: pass-through in receiving
    rxDataIn = 1'b1;
    #1;
    check("R8 serial high", serialOut, 1);
    rxDataIn = 1'b0;
    #1;
    check("R8 serial low", serialOut, 0);

    // R9: bit error ignored
    strobe(1'b0);
    check("R9 bit error keeps receiving", rxActive, 1);
    repeat (5) @(negedge clk);
    check("R9 still receiving", rxActive, 1);

    // R10: forced idle
    forceIdle = 1'b1;
    @(negedge clk);
    check("R10 idle enables off", int'({pllEn, sigEn, checkEn, rxActive}), 0);
    check("R10 control bits kept", int'({supplyEn, clkOn, opMode0}), 3'b111);
    repeat (3) @(negedge clk);
    check("R10 idle held", pllEn, 0);
    forceIdle = 1'b0;
    countUntil(0, n);
    check("R10 restart after release", n, 1);
    countUntil(1, n);
    check("R3 pll after idle", n, PLL_CYC);
    baudRange = 2'd0;
    countUntil(2, n);
    check("R4 range sampled on entry", n, 840);

    // R7: opMode0 set -> fail stays in check
    strobe(1'b0);
    check("R7 fail with opMode0 stays", int'({checkEn, rxActive}), 2'b10);
    // R5: waits without a strobe
    repeat (40) @(negedge clk);
    check("R5 holds bit-check", int'({pllEn, sigEn, checkEn, rxActive}), 4'b1110);

    // R7 and R8: zero sleep field with opMode0 = 0 stays in check
    doReset(2'd3);
    countUntil(0, n);
    countUntil(1, n);
    countUntil(2, n);
    rxDataIn = 1'b1;
    #1;
    check("R8 serial gated outside receiving", serialOut, 0);
    strobe(1'b0);
    check("R7 zero sleep fail stays", int'({checkEn, opMode0}), 2'b10);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule